// File: doc/BRIEF.md
# Single-Bit Taken Predictor Table

This block gives the fetch stage a direction hint for each branch. It holds a direct-mapped array of single-bit entries, and each bit records whether the branch last mapped to that slot went taken or not taken. Fetch presents its program counter and gets the stored bit back in the same cycle. The front end follows that hint without waiting for the branch to resolve.

When a branch resolves later in the pipeline, the update port carries that branch's address and its real outcome, qualified by a valid strobe. The outcome is written into the slot on the next clock edge. If the hint was wrong, that write inverts the bit. If the hint was right, the write leaves the bit as it was. So each slot is a two-state machine, TAKEN or UNTAKEN, that flips on every misprediction.

There is no tag. Any two branch addresses that share the index bits share one slot. A loop branch that is nearly always taken therefore costs two mispredictions per pass of the loop: one at the exit and one when the loop is entered again.

Top module: `takenbit_table`

## Requirements
- R1: After reset is released, every entry reads UNTAKEN, so the hint is 0 for any fetch address.
- R2: The entry index is fetch address bits [IDX_W+1:2]. Address bits outside that field do not select an entry, so two addresses that agree in that field read and write one shared entry.
- R3: An update with the strobe high writes the outcome (1 = taken, 0 = not taken) into the entry it indexes, and a lookup of that entry returns the outcome starting in the cycle after the clock edge.
- R4: An update presented with the strobe low changes no entry.
- R5: The hint is combinational from the fetch address and reflects a changed address within the same cycle.
- R6: When an update and a lookup address the same entry in the same cycle, the lookup returns the value the entry held before that update.
- R7: An update changes only the entry it indexes and leaves every other entry as it was.
- R8: An entry whose hint agreed with the resolved outcome keeps its value. An entry whose hint disagreed is inverted.
- R9: A loop branch that is taken on every iteration except the last mispredicts exactly twice per pass of the loop once it reaches steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset. Clears every entry to UNTAKEN |
| fetch_pc | input | PC_W | Address presented by fetch |
| fetch_hint_taken | output | 1 | Predicted direction for fetch_pc (1 = taken) |
| upd_valid | input | 1 | Qualifies an update from branch resolution |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The hint is due in the same cycle as its address. The bench therefore drives fetch_pc on the falling edge and samples the hint one nanosecond later, before any rising edge. An update is due one edge after it is presented. The bench drives it on the falling edge, lets one rising edge pass, and reads the entry one nanosecond after that edge. For the same-entry collision case, the bench samples twice: once before the edge, where it expects the old bit, and once after the edge, where it expects the new bit. Expected values come from a bench-side array that is indexed by address arithmetic.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
   typedef enum logic {
      DIR_UNTAKEN = 1'b0,
      DIR_TAKEN   = 1'b1
   } dir_e;

   // byte offset of an aligned instruction
   localparam int unsigned INSN_ALIGN_BITS = 2;
endpackage

// File: rtl/tbt_index.sv
module tbt_index #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned LSB   = 2
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   if (LSB + IDX_W > PC_W) begin : g_bad_slice
      $error("tbt_index: index field exceeds address width");
   end

   assign idx = pc[LSB +: IDX_W];
endmodule

// File: rtl/tbt_store.sv
module tbt_store
   import tbt_pkg::*;
#(
   parameter int unsigned IDX_W      = 6,
   parameter bit          INIT_TAKEN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output dir_e             rd_dir,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  dir_e             wr_dir
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   dir_e init_dir;
   dir_e slot_q [DEPTH];

   if (INIT_TAKEN) begin : g_init_t
      assign init_dir = DIR_TAKEN;
   end else begin : g_init_u
      assign init_dir = DIR_UNTAKEN;
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   slot_q[e] <= init_dir;
         else if (hit) slot_q[e] <= wr_dir;
      end
   end

   // read sees the pre-edge contents, so same-cycle collision yields old bit
   assign rd_dir = slot_q[rd_idx];
endmodule

// File: rtl/takenbit_table.sv
module takenbit_table
   import tbt_pkg::*;
#(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned IDX_W      = 6,
   parameter bit          INIT_TAKEN = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            fetch_hint_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);
   localparam int unsigned LSB = INSN_ALIGN_BITS;

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
      $error("takenbit_table: IDX_W must be 1..12");
   end

   logic [IDX_W-1:0] f_idx;
   logic [IDX_W-1:0] u_idx;
   dir_e             f_dir;
   dir_e             u_dir;

   tbt_index #(.PC_W(PC_W), .IDX_W(IDX_W), .LSB(LSB)) fidx_i (
      .pc(fetch_pc), .idx(f_idx));

   tbt_index #(.PC_W(PC_W), .IDX_W(IDX_W), .LSB(LSB)) uidx_i (
      .pc(upd_pc), .idx(u_idx));

   assign u_dir = upd_taken ? DIR_TAKEN : DIR_UNTAKEN;

   tbt_store #(.IDX_W(IDX_W), .INIT_TAKEN(INIT_TAKEN)) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (f_idx),
      .rd_dir (f_dir),
      .wr_en  (upd_valid),
      .wr_idx (u_idx),
      .wr_dir (u_dir)
   );

   assign fetch_hint_taken = (f_dir == DIR_TAKEN);
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned IDX_W      = 6,
   parameter bit          INIT_TAKEN = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic            fetch_hint_taken,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic            upd_taken
);
   logic [IDX_W-1:0] fi, ui;
   assign fi = fetch_pc[2 +: IDX_W];
   assign ui = upd_pc[2 +: IDX_W];

   // R1: right after reset release every slot holds the reset direction
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fetch_hint_taken == INIT_TAKEN));

   // R3: written outcome is visible one edge later
   a_r3_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> (fi != $past(ui)) || (fetch_hint_taken == $past(upd_taken)));

   // R4: no strobe, same slot looked up -> hint unchanged
   a_r4_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> (fi != $past(fi)) || $stable(fetch_hint_taken));

   // R7: write to another slot leaves the looked-up slot alone
   a_r7_other_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && ui != fi) |=> (fi != $past(fi)) || $stable(fetch_hint_taken));

   // R6: collision cycle still reads the old bit
   a_r6_read_old: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && ui == fi && !$past(upd_valid) && fi == $past(fi))
         |-> $stable(fetch_hint_taken));

   // R5: hint is always a defined level
   a_r5_defined: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(fetch_hint_taken));
endmodule

bind takenbit_table tbt_checker #(
   .PC_W(PC_W), .IDX_W(IDX_W), .INIT_TAKEN(INIT_TAKEN)
) chk_i (
   .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
   .fetch_hint_taken(fetch_hint_taken), .upd_valid(upd_valid),
   .upd_pc(upd_pc), .upd_taken(upd_taken)
);

// File: tb/takenbit_table_tb_top.sv
`timescale 1ns/1ps
module takenbit_table_tb_top;
   localparam int PC_W  = 32;
   localparam int IDX_W = 6;
   localparam int DEPTH = 1 << IDX_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic            fetch_hint_taken;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic            upd_taken = 1'b0;

   int  checks = 0;
   int  fails  = 0;
   bit  model [DEPTH];
   bit  done = 1'b0;

   always #4 clk = ~clk;

   takenbit_table #(.PC_W(PC_W), .IDX_W(IDX_W), .INIT_TAKEN(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .fetch_hint_taken(fetch_hint_taken), .upd_valid(upd_valid),
      .upd_pc(upd_pc), .upd_taken(upd_taken));

   function automatic logic [PC_W-1:0] pc_of(int idx, int hi);
      return (PC_W'(hi) << (IDX_W + 2)) | (PC_W'(idx) << 2) | PC_W'(hi & 3);
   endfunction

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic look(logic [PC_W-1:0] pc, string req, logic exp);
      @(negedge clk);
      fetch_pc = pc;
      #1 check(req, fetch_hint_taken, exp);
   endtask

   task automatic write(logic [PC_W-1:0] pc, logic t, logic v);
      @(negedge clk);
      upd_valid = v; upd_pc = pc; upd_taken = t;
      @(posedge clk);
      #1 upd_valid = 1'b0;
      if (v) model[pc[2 +: IDX_W]] = t;
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got hang expected finish");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int miss;
      logic p;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: every slot untaken after reset
      for (int i = 0; i < DEPTH; i++) look(pc_of(i, i * 7), "R1", 1'b0);

      // R3: sweep writes, then sweep reads (R7: others untouched between)
      for (int i = 0; i < DEPTH; i++) write(pc_of(i, 1), (i % 3 == 0), 1'b1);
      for (int i = 0; i < DEPTH; i++) look(pc_of(i, 1), "R3", model[i]);

      // R2: alias addresses with different upper bits share a slot
      for (int i = 0; i < DEPTH; i += 5) begin
         write(pc_of(i, 9), ~model[i], 1'b1);
         look(pc_of(i, 2000 + i), "R2", model[i]);
      end

      // R4: strobe low changes nothing
      for (int i = 0; i < DEPTH; i += 4) begin
         write(pc_of(i, 3), ~model[i], 1'b0);
         look(pc_of(i, 3), "R4", model[i]);
      end

      // R7: write slot 10, neighbours keep values
      write(pc_of(10, 0), ~model[10], 1'b1);
      look(pc_of(9, 0), "R7", model[9]);
      look(pc_of(11, 0), "R7", model[11]);
      look(pc_of(10, 0), "R7", model[10]);

      // R5: same-cycle response to address change
      @(negedge clk);
      fetch_pc = pc_of(0, 0);
      #1 check("R5", fetch_hint_taken, model[0]);
      fetch_pc = pc_of(1, 0);
      #1 check("R5", fetch_hint_taken, model[1]);

      // R6: collision returns old bit, new bit after the edge
      @(negedge clk);
      fetch_pc = pc_of(20, 0);
      upd_valid = 1'b1; upd_pc = pc_of(20, 4); upd_taken = ~model[20];
      #1 check("R6", fetch_hint_taken, model[20]);
      @(posedge clk);
      #1 upd_valid = 1'b0;
      model[20] = ~model[20];
      check("R6", fetch_hint_taken, model[20]);

      // R8: correct hint keeps bit, wrong hint inverts it
      write(pc_of(30, 0), model[30], 1'b1);
      look(pc_of(30, 0), "R8", model[30]);
      write(pc_of(30, 0), ~model[30], 1'b1);
      look(pc_of(30, 0), "R8", model[30]);

      // R9: loop of 8 iterations (7 taken, 1 exit), second pass misses twice
      write(pc_of(40, 0), 1'b0, 1'b1);
      for (int pass = 0; pass < 3; pass++) begin
         miss = 0;
         for (int it = 0; it < 8; it++) begin
            @(negedge clk);
            fetch_pc = pc_of(40, 0);
            #1 p = fetch_hint_taken;
            if (p != (it < 7)) miss++;
            write(pc_of(40, 0), (it < 7), 1'b1);
         end
         if (pass > 0) check("R9", (miss == 2), 1'b1);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule